// File: doc/BRIEF.md
# Dual-Mode Digital Phase Comparator

This block measures the phase relation between a reference signal and a feedback signal, usually a divided-down oscillator output, inside one synchronous clock domain. Both inputs are brought into the clock domain by a synchroniser chain. Two detectors then run side by side, and the surrounding loop uses whichever one suits it.

The first detector is an exclusive-OR of the two synchronised inputs. It suits inputs with a 50% duty cycle. A loop closed around it settles with the inputs a quarter period apart at the centre frequency, and that offset moves toward zero or half a period at the edges of the lock range. It can also settle on harmonics of the reference.

The second detector responds only to rising edges, so duty cycle does not affect it. When the reference edge arrives first it drives a correction upward. When the feedback edge arrives first it drives downward. Once the matching edge from the other input arrives it releases its output. The three-state output is modelled as a drive value plus an enable. A lock flag is high whenever that output is released. A loop closed around this detector settles with the rising edges aligned, and it does not lock onto harmonics. With no reference activity, every feedback edge pushes the oscillator further down.

Top module: `dual_phase_cmp`

## Requirements
- R1: A synchronous active-high reset clears the synchroniser flops, sets the xor output to 0, releases the edge detector output (enable 0) and sets the lock flag to 1.
- R2: `xorErr` equals the exclusive-OR of `refIn` and `fbIn`, delayed by SYNC_STAGES+1 clock cycles (3 by default).
- R3: From the released state, a rising edge on `refIn` alone makes the edge detector drive high (`pfdEn`=1, `pfdDrive`=1), visible SYNC_STAGES+1 cycles after the input edge.
- R4: From the released state, a rising edge on `fbIn` alone makes the edge detector drive low (`pfdEn`=1, `pfdDrive`=0) with the same latency.
- R5: While driving high, a rising edge on `fbIn` releases the output (`pfdEn`=0). While driving low, a rising edge on `refIn` releases it.
- R6: Rising edges on both inputs seen in the same clock cycle leave the output released, or return it to the released state.
- R7: Falling edges and steady levels on either input have no effect on the edge detector output. A repeated reference rising edge while driving high keeps it driving high.
- R8: With `refIn` held low, successive rising edges on `fbIn` keep the edge detector driving low.
- R9: `lockDet` is 1 exactly when `pfdEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | 1 | Reference signal, asynchronous |
| fbIn | input | 1 | Feedback signal, asynchronous |
| xorErr | output | 1 | Exclusive-OR detector error bit |
| pfdDrive | output | 1 | Edge detector drive value (1 up, 0 down) |
| pfdEn | output | 1 | Edge detector output enable (0 = released) |
| lockDet | output | 1 | High while the edge detector output is released |

## Verification
Every result is due SYNC_STAGES+1 = 3 rising clock edges after an input change. Two of those edges are the synchroniser and one is the output register, whether the output comes from the xor flop or from the detector state. The bench changes inputs on a falling edge, waits three falling edges and only then samples the outputs. For latency it also samples one edge early, where the old value must still be present. The checker measures the same window with a parameterised history of the inputs rather than a fixed delay.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    PFD_FLOAT = 2'd0,
    PFD_UP    = 2'd1,
    PFD_DOWN  = 2'd2
  } pfdState_t;

  typedef struct packed {
    logic refRise;
    logic fbRise;
  } edgeStrobe_t;

endpackage

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        refIn,
  input  logic        fbIn,
  output edgeStrobe_t strobes,
  output logic        xorErr
);

  localparam int NUM_CH = 2;
  localparam int TOP    = SYNC_STAGES - 1;

  logic [NUM_CH-1:0] inVec;
  logic [NUM_CH-1:0] synced;
  logic [NUM_CH-1:0] rise;
  logic              xorQ;

  assign inVec = {fbIn, refIn};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], inVec[ch]};
        prevQ <= syncQ[TOP];
      end
    end

    assign synced[ch] = syncQ[TOP];
    assign rise[ch]   = syncQ[TOP] & ~prevQ;
  end

  always_ff @(posedge clk) begin
    if (rst) xorQ <= 1'b0;
    else     xorQ <= synced[0] ^ synced[1];
  end

  assign strobes.refRise = rise[0];
  assign strobes.fbRise  = rise[1];
  assign xorErr          = xorQ;

endmodule

// File: rtl/dpc_control.sv
module dpc_control
  import dpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  edgeStrobe_t strobes,
  output logic        pfdDrive,
  output logic        pfdEn,
  output logic        lockDet
);

  pfdState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      PFD_FLOAT: begin
        if (strobes.refRise && !strobes.fbRise)      stateD = PFD_UP;
        else if (strobes.fbRise && !strobes.refRise) stateD = PFD_DOWN;
      end
      PFD_UP:   if (strobes.fbRise)  stateD = PFD_FLOAT;
      PFD_DOWN: if (strobes.refRise) stateD = PFD_FLOAT;
      default:  stateD = PFD_FLOAT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= PFD_FLOAT;
    else     stateQ <= stateD;
  end

  assign pfdEn    = (stateQ != PFD_FLOAT);
  assign pfdDrive = (stateQ == PFD_UP);
  assign lockDet  = (stateQ == PFD_FLOAT);

endmodule

// File: rtl/dual_phase_cmp.sv
module dual_phase_cmp
  import dpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refIn,
  input  logic fbIn,
  output logic xorErr,
  output logic pfdDrive,
  output logic pfdEn,
  output logic lockDet
);

  edgeStrobe_t strobes;

  dpc_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .refIn   (refIn),
    .fbIn    (fbIn),
    .strobes (strobes),
    .xorErr  (xorErr)
  );

  dpc_control ctl_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .pfdDrive (pfdDrive),
    .pfdEn    (pfdEn),
    .lockDet  (lockDet)
  );

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic refIn,
  input logic fbIn,
  input logic xorErr,
  input logic pfdDrive,
  input logic pfdEn,
  input logic lockDet
);

  localparam int LAT = SYNC_STAGES + 1;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic [1:0]   inHist [0:LAT];
  logic [CW-1:0] okCnt;

  always_ff @(posedge clk) begin
    if (rst) okCnt <= '0;
    else if (okCnt < CW'(LAT + 1)) okCnt <= okCnt + 1'b1;
    inHist[0] <= {refIn, fbIn};
    for (int i = 1; i <= LAT; i++) inHist[i] <= inHist[i-1];
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pfdEn && lockDet && !xorErr));

  // R2
  xor_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (okCnt >= CW'(LAT)) |-> (xorErr == (inHist[LAT-1][1] ^ inHist[LAT-1][0])));

  // R5
  no_up_to_down_chk: assert property (@(posedge clk) disable iff (rst)
    (pfdEn && pfdDrive) |=> !(pfdEn && !pfdDrive));

  // R5
  no_down_to_up_chk: assert property (@(posedge clk) disable iff (rst)
    (pfdEn && !pfdDrive) |=> !(pfdEn && pfdDrive));

  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((okCnt >= CW'(LAT + 1)) && (inHist[LAT-1] == inHist[LAT]))
      |-> ($stable(pfdEn) && $stable(pfdDrive) && $stable(xorErr)));

  // R9
  lock_flag_chk: assert property (@(posedge clk) disable iff (rst)
    lockDet == !pfdEn);

endmodule

bind dual_phase_cmp dpc_checker #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .refIn    (refIn),
  .fbIn     (fbIn),
  .xorErr   (xorErr),
  .pfdDrive (pfdDrive),
  .pfdEn    (pfdEn),
  .lockDet  (lockDet)
);

// File: tb/dual_phase_cmp_tb.sv
`timescale 1ns/1ps
module dual_phase_cmp_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refIn = 1'b0;
  logic fbIn = 1'b0;
  logic xorErr, pfdDrive, pfdEn, lockDet;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_phase_cmp dut_i (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn),
    .xorErr(xorErr), .pfdDrive(pfdDrive), .pfdEn(pfdEn), .lockDet(lockDet)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic r, input logic f);
    @(negedge clk);
    refIn = r;
    fbIn  = f;
  endtask

  task automatic expectPfd(input string req, input logic en, input logic drv);
    check(req, "pfdEn", pfdEn, en);
    if (en) check(req, "pfdDrive", pfdDrive, drv);
    check(req, "lockDet", lockDet, !en);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    refIn = 1'b1;
    waitN(3);
    check("R1", "xorErr", xorErr, 1'b0);
    expectPfd("R1", 1'b0, 1'b0);
    refIn = 1'b0;
    rst = 1'b0;
    waitN(4);
    expectPfd("R1", 1'b0, 1'b0);
  endtask

  task automatic test_ref_leads();
    drive(1'b1, 1'b0);
    waitN(2);
    check("R2", "xorErr early", xorErr, 1'b0);
    expectPfd("R3", 1'b0, 1'b0);
    waitN(1);
    check("R2", "xorErr", xorErr, 1'b1);
    expectPfd("R3", 1'b1, 1'b1);
    drive(1'b1, 1'b1);
    waitN(3);
    check("R2", "xorErr both high", xorErr, 1'b0);
    expectPfd("R5", 1'b0, 1'b0);
    drive(1'b0, 1'b0);
    waitN(3);
    expectPfd("R7", 1'b0, 1'b0);
  endtask

  task automatic test_fb_leads();
    drive(1'b0, 1'b1);
    waitN(3);
    check("R2", "xorErr fb only", xorErr, 1'b1);
    expectPfd("R4", 1'b1, 1'b0);
    drive(1'b1, 1'b1);
    waitN(3);
    expectPfd("R5", 1'b0, 1'b0);
    drive(1'b0, 1'b0);
    waitN(3);
  endtask

  task automatic test_simultaneous();
    drive(1'b1, 1'b1);
    waitN(3);
    expectPfd("R6", 1'b0, 1'b0);
    drive(1'b0, 1'b0);
    waitN(3);
    expectPfd("R6", 1'b0, 1'b0);
  endtask

  task automatic test_duty_ignored();
    drive(1'b1, 1'b0);
    waitN(3);
    expectPfd("R3", 1'b1, 1'b1);
    drive(1'b0, 1'b0);
    waitN(3);
    expectPfd("R7", 1'b1, 1'b1);
    drive(1'b1, 1'b0);
    waitN(3);
    expectPfd("R7", 1'b1, 1'b1);
    drive(1'b1, 1'b1);
    waitN(3);
    expectPfd("R5", 1'b0, 1'b0);
    drive(1'b0, 1'b1);
    waitN(3);
    expectPfd("R7", 1'b0, 1'b0);
    drive(1'b0, 1'b0);
    waitN(3);
  endtask

  task automatic test_no_reference();
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 1'b1);
      waitN(3);
      expectPfd("R8", 1'b1, 1'b0);
      drive(1'b0, 1'b0);
      waitN(3);
      expectPfd("R8", 1'b1, 1'b0);
    end
  endtask

  task automatic test_reset_midrun();
    @(negedge clk);
    rst = 1'b1;
    waitN(1);
    expectPfd("R1", 1'b0, 1'b0);
    check("R1", "xorErr", xorErr, 1'b0);
    rst = 1'b0;
    waitN(3);
  endtask

  initial begin
    test_reset();
    test_ref_leads();
    test_fb_leads();
    test_simultaneous();
    test_duty_ignored();
    test_no_reference();
    test_reset_midrun();
    test_ref_leads();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule